// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This unit keeps the exception side of a floating-point status register. Whenever an arithmetic operation completes, the datapath pulses `op_done` and presents the five IEEE exception flags on `op_flags`. The unit then updates its state on the next clock edge.

It compares the flags against a software-loaded trap-enable mask. If any enabled flag is set, the unit records an IEEE-exception trap type and raises a one-cycle trap request. The accrued history is frozen in this case. If no enabled flag is set, the flags are merged into the accrued history and the trap type returns to zero.

The unit also holds a two-bit rounding-direction field and decodes it into a one-hot select for the datapath. Software loads the status through a full write. It can also use a partial write that keeps the trap-type field unchanged. The complete status word can be read at all times.

A two-state machine drives the trap request:
- `ST_RUN` is the quiet state.
- `ST_TRAP` is held for exactly the cycle that follows a trapping completion.

The transitions are:
- *arm*: `ST_RUN` to `ST_TRAP`, on `op_done` with an enabled flag.
- *retrap*: `ST_TRAP` to `ST_TRAP`, when another trapping completion arrives at once.
- *release*: `ST_TRAP` to `ST_RUN`, on any other cycle.
- *idle*: `ST_RUN` to `ST_RUN`, on any other cycle.

Top module: `fpx_status`

## Requirements
- R1: On a cycle with `op_done` high, the flags map one-to-one onto the current-exception field after the next clock edge: invalid to bit 4, overflow to bit 3, underflow to bit 2, divide-by-zero to bit 1, inexact to bit 0. The same order applies to the mask and accrued fields.
- R2: When `op_done` is high and `op_flags & mask` is nonzero, `trap_req` is high for the cycle after the edge, and the trap-type field reads 1 (IEEE exception). Otherwise `trap_req` is low.
- R3: On a trapping completion, the accrued field keeps its previous value.
- R4: On a non-trapping completion, the flags are ORed into the accrued field and the trap-type field becomes 0.
- R5: A completion with no flags set clears both the current field and the trap-type field.
- R6: `rnd_sel` is one-hot and follows the rounding field: code 0 gives bit 0 (nearest-even), code 1 gives bit 1 (toward zero), code 2 gives bit 2 (toward +infinity), code 3 gives bit 3 (toward -infinity).
- R7: A full write (`wr_full`) loads the status word, with this field layout:
  - current: bits [4:0]
  - accrued: bits [9:5]
  - mask: bits [14:10]
  - rounding: bits [17:16]
  - trap type: bits [20:18]
  - all other bits of `stat_word` read 0.
- R8: A partial write (`wr_part`) loads current, accrued, mask and rounding, and leaves the trap-type field unchanged.
- R9: `op_done` takes priority over both writes in the same cycle. A full write takes priority over a partial write.
- R10: After reset, every field is zero: the rounding mode is nearest-even, all traps are masked, and `trap_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_done | input | 1 | Completion strobe from the datapath |
| op_flags | input | 5 | IEEE flags of the completing operation (nv, of, uf, dz, nx from bit 4 down) |
| wr_full | input | 1 | Full status write strobe |
| wr_part | input | 1 | Partial status write strobe (trap type kept) |
| wr_data | input | 32 | Written status word |
| stat_word | output | 32 | Assembled status word |
| trap_req | output | 1 | Trap request, one cycle per trapping completion |
| rnd_sel | output | 4 | One-hot rounding-direction select |

## Verification
The embedded properties check on every cycle:
- the coupling of the trap request with the IEEE trap type;
- the frozen accrued field after a trapping completion;
- the trap-type clear and flag capture after a non-trapping completion;
- trap-type preservation across a lone partial write;
- the one-hot shape of the rounding select.

Only the bench scenarios can show the remaining behaviour:
- the exact bit placement of every field;
- accumulation across long runs of completions;
- the write priority ordering;
- the reset values.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int FLAG_W   = 5;
    localparam int RD_W     = 2;
    localparam int FTT_W    = 3;
    localparam int CEXC_LSB = 0;
    localparam int AEXC_LSB = CEXC_LSB + FLAG_W;
    localparam int TEM_LSB  = AEXC_LSB + FLAG_W;
    localparam int RD_LSB   = 16;
    localparam int FTT_LSB  = RD_LSB + RD_W;
    localparam int USED_W   = FTT_LSB + FTT_W;

    localparam logic [FTT_W-1:0] FTT_NONE = 3'd0;
    localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;

    typedef enum logic {
        ST_RUN,
        ST_TRAP
    } trap_st_e;
endpackage

// File: rtl/fpx_flag_eval.sv
module fpx_flag_eval #(
    parameter int W = 5
) (
    input  logic [W-1:0] flags,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] accrued,
    output logic         hit,
    output logic [W-1:0] merged
);
    always_comb begin
        hit    = |(flags & mask);
        merged = accrued | flags;
    end
endmodule

// File: rtl/fpx_rnd_decode.sv
module fpx_rnd_decode #(
    parameter int RW = 2,
    localparam int N = 1 << RW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] code,
    output logic [N-1:0]  sel
);
    for (genvar i = 0; i < N; i++) begin : g_dec
        assign sel[i] = (code == RW'(i));
    end

    // R6
    rnd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) == 1);
endmodule

// File: rtl/fpx_status.sv
module fpx_status #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_done,
    input  logic [4:0]        op_flags,
    input  logic              wr_full,
    input  logic              wr_part,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] stat_word,
    output logic              trap_req,
    output logic [3:0]        rnd_sel
);
    import fpx_pkg::*;

    trap_st_e          st_q, st_d;
    logic [FLAG_W-1:0] cexc_q, aexc_q, tem_q, merged;
    logic [RD_W-1:0]   rd_q;
    logic [FTT_W-1:0]  ftt_q;
    logic              hit;

    fpx_flag_eval #(.W(FLAG_W)) u_eval (
        .flags   (op_flags),
        .mask    (tem_q),
        .accrued (aexc_q),
        .hit     (hit),
        .merged  (merged)
    );

    fpx_rnd_decode #(.RW(RD_W)) u_rnd (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (rd_q),
        .sel   (rnd_sel)
    );

    // next-state logic for the trap request machine
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:  st_d = (op_done && hit) ? ST_TRAP : ST_RUN;
            ST_TRAP: st_d = (op_done && hit) ? ST_TRAP : ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // status fields; completion beats full write beats partial write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cexc_q <= '0;
            aexc_q <= '0;
            tem_q  <= '0;
            rd_q   <= '0;
            ftt_q  <= FTT_NONE;
        end else if (op_done) begin
            cexc_q <= op_flags;
            if (hit) begin
                ftt_q <= FTT_IEEE;
            end else begin
                aexc_q <= merged;
                ftt_q  <= FTT_NONE;
            end
        end else if (wr_full || wr_part) begin
            cexc_q <= wr_data[CEXC_LSB +: FLAG_W];
            aexc_q <= wr_data[AEXC_LSB +: FLAG_W];
            tem_q  <= wr_data[TEM_LSB  +: FLAG_W];
            rd_q   <= wr_data[RD_LSB   +: RD_W];
            if (wr_full) ftt_q <= wr_data[FTT_LSB +: FTT_W];
        end
    end

    // outputs
    always_comb begin
        trap_req = (st_q == ST_TRAP);
        stat_word = '0;
        stat_word[CEXC_LSB +: FLAG_W] = cexc_q;
        stat_word[AEXC_LSB +: FLAG_W] = aexc_q;
        stat_word[TEM_LSB  +: FLAG_W] = tem_q;
        stat_word[RD_LSB   +: RD_W]   = rd_q;
        stat_word[FTT_LSB  +: FTT_W]  = ftt_q;
    end

    // R2
    trap_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> stat_word[FTT_LSB +: FTT_W] == FTT_IEEE);
    // R3
    accrued_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && |(op_flags & stat_word[TEM_LSB +: FLAG_W]))
        |=> stat_word[AEXC_LSB +: FLAG_W] == $past(stat_word[AEXC_LSB +: FLAG_W]) && trap_req);
    // R4
    no_trap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !(|(op_flags & stat_word[TEM_LSB +: FLAG_W])))
        |=> stat_word[FTT_LSB +: FTT_W] == FTT_NONE && !trap_req
            && stat_word[CEXC_LSB +: FLAG_W] == $past(op_flags));
    // R8
    part_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_part && !wr_full && !op_done)
        |=> $stable(stat_word[FTT_LSB +: FTT_W]));
endmodule

// File: tb/fpx_status_test.sv
`timescale 1ns/1ps
module fpx_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_done = 1'b0;
    logic [4:0]  op_flags = '0;
    logic        wr_full = 1'b0;
    logic        wr_part = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] stat_word;
    logic        trap_req;
    logic [3:0]  rnd_sel;

    int checks = 0;
    int errors = 0;

    // bench model of the status fields
    logic [4:0] m_cexc = '0, m_aexc = '0, m_tem = '0;
    logic [1:0] m_rd = '0;
    logic [2:0] m_ftt = '0;
    logic       m_trap = 1'b0;

    always #10 clk = ~clk;

    fpx_status uut (
        .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_flags(op_flags),
        .wr_full(wr_full), .wr_part(wr_part), .wr_data(wr_data),
        .stat_word(stat_word), .trap_req(trap_req), .rnd_sel(rnd_sel)
    );

    function automatic logic [31:0] pack(input logic [4:0] c, input logic [4:0] a,
                                         input logic [4:0] t, input logic [1:0] r,
                                         input logic [2:0] f);
        logic [31:0] w = '0;
        w[4:0] = c; w[9:5] = a; w[14:10] = t; w[17:16] = r; w[20:18] = f;
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, stat_word, pack(m_cexc, m_aexc, m_tem, m_rd, m_ftt));
        chk("R2 trap_req", {31'd0, trap_req}, {31'd0, m_trap});
        chk("R6 rnd_sel", {28'd0, rnd_sel}, 32'd1 << m_rd);
    endtask

    task automatic step(input logic op, input logic [4:0] fl, input logic wf,
                        input logic wp, input logic [31:0] d, input string tag);
        op_done = op; op_flags = fl; wr_full = wf; wr_part = wp; wr_data = d;
        if (op) begin
            m_cexc = fl;
            m_trap = |(fl & m_tem);
            if (m_trap) m_ftt = 3'd1;
            else begin m_aexc = m_aexc | fl; m_ftt = 3'd0; end
        end else begin
            m_trap = 1'b0;
            if (wf || wp) begin
                m_cexc = d[4:0]; m_aexc = d[9:5]; m_tem = d[14:10]; m_rd = d[17:16];
                if (wf) m_ftt = d[20:18];
            end
        end
        @(negedge clk);
        op_done = 1'b0; wr_full = 1'b0; wr_part = 1'b0;
        check_all(tag);
    endtask

    initial begin
        #(20.0 * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_all("R10 reset");

        // R6: every rounding code, R7: full write layout
        for (int r = 0; r < 4; r++)
            step(0, 0, 1, 0, pack(5'h15, 5'h0a, 5'h00, 2'(r), 3'd5), "R7 full write");
        // R8: partial write keeps trap type 5
        step(0, 0, 0, 1, pack(5'h03, 5'h00, 5'h10, 2'd0, 3'd2), "R8 partial write");
        // R1/R4: non-trapping completion, overflow + inexact
        step(1, 5'b01001, 0, 0, 0, "R1 R4 no trap");
        // R2/R3: invalid is enabled -> trap, accrued frozen
        step(1, 5'b10010, 0, 0, 0, "R2 R3 trap");
        // back-to-back trap
        step(1, 5'b10000, 0, 0, 0, "R2 retrap");
        // R5: no flags
        step(1, 5'b00000, 0, 0, 0, "R5 no flags");
        // R9: completion beats full write
        step(1, 5'b00100, 1, 0, 32'h001F_FFFF, "R9 op priority");
        // R9: full beats partial
        step(0, 0, 1, 1, pack(5'h01, 5'h02, 5'h04, 2'd3, 3'd6), "R9 full over part");

        for (int i = 0; i < 400; i++) begin
            logic op, wf, wp;
            logic [4:0] fl;
            logic [31:0] d;
            string tag;
            op = ($urandom % 10) < 4;
            wf = ($urandom % 10) == 0;
            wp = ($urandom % 10) == 0;
            fl = 5'($urandom);
            if ($urandom % 4 == 0) fl = '0;
            d = $urandom & 32'h001F_7FFF;
            if (op) tag = (|(fl & m_tem)) ? "R3 rand trap" : ((fl == 0) ? "R5 rand" : "R4 rand");
            else if (wf) tag = "R7 rand";
            else if (wp) tag = "R8 rand";
            else tag = "R1 rand idle";
            step(op, fl, wf, wp, d, tag);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule